// File: doc/BRIEF.md
# Indirect Delay-Tap Access Port

This block gives software access to a small bank of per-speed-mode delay taps through a single 32-bit command register. The taps are kept in flops and feed the interface's delay lines. Each entry is indexed by the signalling mode it serves. Software first loads an entry index and a 4-bit value into the command register with both strobe bits clear. It then writes the register again with the write strobe set, and a third time with the strobe cleared. The block commits the value once, on the rising edge of the strobe.

A read works the same way through the read strobe. On its rising edge the addressed entry is copied into a read-data field of the command register, where software can read it back. An acknowledge bit tells software that a strobe edge has been serviced. It stays set until software clears both strobes. Every entry leaves reset holding its mode's default delay, so the delay lines are usable before any software runs.

The register sits on a plain write-enable bus. Reads of the register are combinational on the bus address.

Top module: `phy_dly_port`

## Requirements
- R1: After reset, tap entries hold index 0x00 = 4, 0x01 = 4, 0x06 = 9, 0x07 = 2, 0x08 = 3, and 0 for indices 0x02 to 0x05. The command register reads 0.
- R2: The command register answers only at bus offset 0x10. Its fields are: index in bits 7:0, write value in bits 11:8, read-back value in bits 15:12, write strobe in bit 24, read strobe in bit 25 and acknowledge in bit 26. Bus writes to any other offset change nothing, and bus reads of any other offset return 0.
- R3: The addressed entry takes the write value exactly once per rising edge of bit 24, on the second clock edge after the bus write that raises the strobe. Rewriting the register with the strobe still high and a new value or index has no effect.
- R4: A rising edge of bit 25 copies the addressed entry into bits 15:12, visible on the second clock edge after the bus write that raises the strobe.
- R5: A write strobe edge aimed at an index above 0x08 changes no entry. A read strobe edge aimed at such an index returns 0.
- R6: Bit 26 becomes 1 together with the serviced write or read. It returns to 0 one clock edge after a bus write that leaves bits 24 and 25 both clear.
- R7: Output `dly_tap_o` carries entry i in bits 4*i+3 : 4*i.
- R8: When both strobes rise in the same bus write, the read-back field receives the entry's contents from before the write, and the entry takes the new value.
- R9: Bits 15:12 change only on a serviced read. Bus write data in those bits is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr_en | input | 1 | Bus write enable |
| bus_addr | input | 8 | Bus byte offset |
| bus_wdata | input | 32 | Bus write data |
| bus_rdata | output | 32 | Bus read data, combinational on `bus_addr` |
| dly_tap_o | output | 36 | Packed delay taps, 4 bits per entry |

## Verification
A corrupted entry shows at once on `dly_tap_o`, one edge after the faulty commit. It also shows in the read-back field two edges after the next read strobe. If the strobe edge detector holds the wrong state, it shows up as a second commit while the strobe is held high, or as a missed commit after a clean low-high sequence. Either one is visible on the taps in the following cycle. A stuck acknowledge is visible on a bus read of offset 0x10 within two edges of the strobe being raised or cleared.

// File: rtl/phy_dly_pkg.sv
package phy_dly_pkg;
  localparam int CMD_W      = 32;
  localparam int IDX_W      = 8;
  localparam int VAL_W      = 4;
  localparam int IDX_LSB    = 0;
  localparam int WVAL_LSB   = 8;
  localparam int RVAL_LSB   = 12;
  localparam int WSTB_BIT   = 24;
  localparam int RSTB_BIT   = 25;
  localparam int ACK_BIT    = 26;
  localparam int N_ENTRIES  = 9;

  typedef struct packed {
    logic [IDX_W-1:0] idx;
    logic [VAL_W-1:0] wval;
    logic             wstb;
    logic             rstb;
  } cmd_fields_t;

  // Default delay per mode index
  function automatic logic [VAL_W-1:0] reset_delay(input int entry);
    case (entry)
      0, 1:    return VAL_W'(4);
      6:       return VAL_W'(9);
      7:       return VAL_W'(2);
      8:       return VAL_W'(3);
      default: return '0;
    endcase
  endfunction

  function automatic logic idx_in_bank(input logic [IDX_W-1:0] idx, input int n);
    return int'(idx) < n;
  endfunction

  // Assemble the software-visible view of the command register
  function automatic logic [CMD_W-1:0] pack_view(input cmd_fields_t c,
                                                 input logic [VAL_W-1:0] rval,
                                                 input logic ack);
    logic [CMD_W-1:0] v;
    v = '0;
    v[IDX_LSB  +: IDX_W] = c.idx;
    v[WVAL_LSB +: VAL_W] = c.wval;
    v[RVAL_LSB +: VAL_W] = rval;
    v[WSTB_BIT]          = c.wstb;
    v[RSTB_BIT]          = c.rstb;
    v[ACK_BIT]           = ack;
    return v;
  endfunction
endpackage

// File: rtl/phy_dly_cmd.sv
module phy_dly_cmd
  import phy_dly_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [CMD_W-1:0]  load_data,
  output cmd_fields_t       cmd,
  output logic              wr_fire,
  output logic              rd_fire
);
  logic wstb_prev, rstb_prev;
  logic [CMD_W-1:0] unused_bits;

  assign unused_bits = load_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd <= '0;
    end else if (load) begin
      cmd.idx  <= load_data[IDX_LSB +: IDX_W];
      cmd.wval <= load_data[WVAL_LSB +: VAL_W];
      cmd.wstb <= load_data[WSTB_BIT];
      cmd.rstb <= load_data[RSTB_BIT];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wstb_prev <= 1'b0;
      rstb_prev <= 1'b0;
    end else begin
      wstb_prev <= cmd.wstb;
      rstb_prev <= cmd.rstb;
    end
  end

  assign wr_fire = cmd.wstb & ~wstb_prev;
  assign rd_fire = cmd.rstb & ~rstb_prev;
endmodule

// File: rtl/phy_dly_bank.sv
module phy_dly_bank
  import phy_dly_pkg::*;
#(
  parameter int NUM = N_ENTRIES,
  parameter int DW  = VAL_W,
  parameter int AW  = IDX_W
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_fire,
  input  logic [AW-1:0]   idx,
  input  logic [DW-1:0]   wval,
  output logic [NUM*DW-1:0] taps,
  output logic [DW-1:0]   rd_val
);
  logic [DW-1:0] entry_q [NUM];

  for (genvar g = 0; g < NUM; g++) begin : g_entry
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        entry_q[g] <= DW'(reset_delay(g));
      else if (wr_fire && idx == AW'(g))
        entry_q[g] <= wval;
    end
    assign taps[g*DW +: DW] = entry_q[g];
  end

  always_comb begin
    rd_val = '0;
    for (int k = 0; k < NUM; k++)
      if (idx == AW'(k)) rd_val = entry_q[k];
  end
endmodule

// File: rtl/phy_dly_ack.sv
module phy_dly_ack
  import phy_dly_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_fire,
  input  logic             rd_fire,
  input  logic             wstb,
  input  logic             rstb,
  input  logic [VAL_W-1:0] rd_val,
  output logic             ack,
  output logic [VAL_W-1:0] rval
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ack  <= 1'b0;
      rval <= '0;
    end else begin
      if (rd_fire) rval <= rd_val;
      if (wr_fire || rd_fire) ack <= 1'b1;
      else if (!wstb && !rstb) ack <= 1'b0;
    end
  end
endmodule

// File: rtl/phy_dly_port.sv
module phy_dly_port
  import phy_dly_pkg::*;
#(
  parameter int            BUS_AW     = 8,
  parameter int            NUM        = N_ENTRIES,
  parameter logic [BUS_AW-1:0] CMD_OFFSET = BUS_AW'('h10),
  localparam int           TAP_W      = NUM * VAL_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr_en,
  input  logic [BUS_AW-1:0] bus_addr,
  input  logic [CMD_W-1:0]  bus_wdata,
  output logic [CMD_W-1:0]  bus_rdata,
  output logic [TAP_W-1:0]  dly_tap_o
);
  cmd_fields_t      cmd;
  logic             hit;
  logic             wr_fire, rd_fire;
  logic             ack;
  logic [VAL_W-1:0] rd_val, rval;

  assign hit = (bus_addr == CMD_OFFSET);

  phy_dly_cmd u_cmd (
    .clk(clk), .rst_n(rst_n),
    .load(bus_wr_en && hit), .load_data(bus_wdata),
    .cmd(cmd), .wr_fire(wr_fire), .rd_fire(rd_fire)
  );

  phy_dly_bank #(.NUM(NUM), .DW(VAL_W), .AW(IDX_W)) u_bank (
    .clk(clk), .rst_n(rst_n),
    .wr_fire(wr_fire && idx_in_bank(cmd.idx, NUM)),
    .idx(cmd.idx), .wval(cmd.wval),
    .taps(dly_tap_o), .rd_val(rd_val)
  );

  phy_dly_ack u_ack (
    .clk(clk), .rst_n(rst_n),
    .wr_fire(wr_fire), .rd_fire(rd_fire),
    .wstb(cmd.wstb), .rstb(cmd.rstb),
    .rd_val(rd_val), .ack(ack), .rval(rval)
  );

  assign bus_rdata = hit ? pack_view(cmd, rval, ack) : '0;
endmodule

// File: rtl/phy_dly_port_chk.sv
module phy_dly_port_chk
  import phy_dly_pkg::*;
#(
  parameter int NUM = N_ENTRIES
) (
  input logic               clk,
  input logic               rst_n,
  input logic               wr_fire,
  input logic               rd_fire,
  input logic               wstb,
  input logic               rstb,
  input logic               ack,
  input logic [IDX_W-1:0]   idx,
  input logic [NUM*VAL_W-1:0] taps,
  input logic [VAL_W-1:0]   rval
);
  AST_FIRE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_fire |=> !wr_fire);                                        // R3
  AST_TAPS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_fire |=> $stable(taps));                                  // R3
  AST_OOR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_fire && int'(idx) >= NUM) |=> $stable(taps));             // R5
  AST_ACK_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_fire || rd_fire) |=> ack);                                // R6
  AST_ACK_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    (!wstb && !rstb) |=> !ack);                                   // R6
  AST_RVAL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_fire |=> $stable(rval));                                  // R9
endmodule

bind phy_dly_port phy_dly_port_chk #(.NUM(NUM)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_fire(wr_fire), .rd_fire(rd_fire),
  .wstb(cmd.wstb), .rstb(cmd.rstb), .ack(ack), .idx(cmd.idx),
  .taps(dly_tap_o), .rval(rval)
);

// File: tb/test_phy_dly_port.sv
`timescale 1ns/1ps
module test_phy_dly_port;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr_en = 1'b0;
  logic [7:0]  bus_addr = 8'h00;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [35:0] dly_tap_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;
  logic [3:0] mdl [9];

  phy_dly_port i_phy_dly_port (
    .clk(clk), .rst_n(rst_n), .bus_wr_en(bus_wr_en), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .dly_tap_o(dly_tap_o)
  );

  always #2 clk = ~clk;

  // {index, value}
  localparam logic [11:0] VEC [12] = '{
    {8'h00, 4'h1}, {8'h01, 4'hF}, {8'h02, 4'h7}, {8'h03, 4'h8},
    {8'h04, 4'hA}, {8'h05, 4'h5}, {8'h06, 4'h0}, {8'h08, 4'hC},
    {8'h09, 4'hE}, {8'hFF, 4'h6}, {8'h07, 4'h3}, {8'h06, 4'hB}
  };

  function automatic logic [35:0] model_taps();
    logic [35:0] t;
    for (int k = 0; k < 9; k++) t[k*4 +: 4] = mdl[k];
    return t;
  endfunction

  task automatic chk(input string req, input logic [35:0] act, input logic [35:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr_en = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr_en = 1'b0; bus_addr = 8'h10;
  endtask

  function automatic logic [31:0] cmdw(input logic [7:0] idx, input logic [3:0] v,
                                       input logic ws, input logic rs);
    return {6'b0, rs, ws, 8'h00, 4'h0, v, idx};
  endfunction

  task automatic rd_cmd(output logic [31:0] v);
    bus_addr = 8'h10; #0.5; v = bus_rdata;
  endtask

  task automatic phy_write(input logic [7:0] idx, input logic [3:0] v);
    logic [31:0] r;
    bus_wr(8'h10, cmdw(idx, v, 1'b0, 1'b0));
    bus_wr(8'h10, cmdw(idx, v, 1'b1, 1'b0));
    @(negedge clk);
    rd_cmd(r);
    chk("R6 ack after write", 36'(r[26]), 36'd1);
    bus_wr(8'h10, cmdw(idx, v, 1'b0, 1'b0));
    @(negedge clk);
    rd_cmd(r);
    chk("R6 ack cleared", 36'(r[26]), 36'd0);
    if (int'(idx) < 9) mdl[idx] = v;
  endtask

  task automatic phy_read(input logic [7:0] idx, output logic [3:0] v);
    logic [31:0] r;
    bus_wr(8'h10, cmdw(idx, 4'h0, 1'b0, 1'b0));
    bus_wr(8'h10, cmdw(idx, 4'h0, 1'b0, 1'b1));
    @(negedge clk);
    rd_cmd(r);
    v = r[15:12];
    bus_wr(8'h10, cmdw(idx, 4'h0, 1'b0, 1'b0));
    @(negedge clk);
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] r;
    logic [3:0]  rv;
    for (int k = 0; k < 9; k++) mdl[k] = 4'h0;
    mdl[0] = 4; mdl[1] = 4; mdl[6] = 9; mdl[7] = 2; mdl[8] = 3;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 / R7: reset taps and command view
    chk("R1 reset taps", dly_tap_o, model_taps());
    chk("R7 tap packing entry 6", 36'(dly_tap_o[27:24]), 36'd9);
    rd_cmd(r);
    chk("R1 command reads zero", 36'(r), 36'd0);
    phy_read(8'h08, rv);
    chk("R4 read of reset entry 8", 36'(rv), 36'd3);

    // Table walk: write, then read back
    for (int i = 0; i < 12; i++) begin
      phy_write(VEC[i][11:4], VEC[i][3:0]);
      chk("R3 taps after write", dly_tap_o, model_taps());
      phy_read(VEC[i][11:4], rv);
      chk((int'(VEC[i][11:4]) < 9) ? "R4 read back" : "R5 out-of-range read zero",
          36'(rv), (int'(VEC[i][11:4]) < 9) ? 36'(mdl[VEC[i][11:4]]) : 36'd0);
    end
    chk("R5 taps unchanged by out-of-range", dly_tap_o, model_taps());

    // R3: strobe held high, new value and index ignored
    bus_wr(8'h10, cmdw(8'h02, 4'h9, 1'b0, 1'b0));
    bus_wr(8'h10, cmdw(8'h02, 4'h9, 1'b1, 1'b0));
    mdl[2] = 4'h9;
    bus_wr(8'h10, cmdw(8'h03, 4'h1, 1'b1, 1'b0));
    bus_wr(8'h10, cmdw(8'h02, 4'h4, 1'b1, 1'b0));
    @(negedge clk);
    chk("R3 held strobe single commit", dly_tap_o, model_taps());
    bus_wr(8'h10, cmdw(8'h02, 4'h4, 1'b0, 1'b0));
    @(negedge clk);

    // R2: other offset ignored, reads zero
    bus_wr(8'h14, cmdw(8'h00, 4'hD, 1'b1, 1'b1));
    repeat (2) @(negedge clk);
    chk("R2 other offset no commit", dly_tap_o, model_taps());
    bus_addr = 8'h14; #0.5;
    chk("R2 other offset reads zero", 36'(bus_rdata), 36'd0);
    rd_cmd(r);
    chk("R2 command unchanged", 36'(r[26:0]), 36'(cmdw(8'h02, 4'h4, 1'b0, 1'b0)) | 36'(32'(mdl[6]) << 12));

    // R8: both strobes rise together on entry 7 (holds 3)
    bus_wr(8'h10, cmdw(8'h07, 4'hA, 1'b0, 1'b0));
    bus_wr(8'h10, cmdw(8'h07, 4'hA, 1'b1, 1'b1));
    @(negedge clk);
    rd_cmd(r);
    mdl[7] = 4'hA;
    chk("R8 read gets old value", 36'(r[15:12]), 36'd3);
    chk("R8 entry takes new value", dly_tap_o, model_taps());

    // R9: bus data in read-back bits ignored
    bus_wr(8'h10, 32'h0000_F000);
    @(negedge clk);
    rd_cmd(r);
    chk("R9 read-back field ignores bus data", 36'(r[15:12]), 36'd3);
    chk("R6 ack clears after strobes low", 36'(r[26]), 36'd0);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule